// File: doc/BRIEF.md
# MII Ethernet Frame Transmitter

This block turns a payload held in a processor-side word buffer into a complete Ethernet frame on the transmit half of a Media Independent Interface, one nibble per clock. A single start pulse with a byte count launches the frame. The block then sends the preamble and start delimiter, serialises the payload out of 32-bit words, adds zero padding when the payload is short, and ends the frame with the 32-bit frame check sequence. That sequence is computed on the fly over every body nibble sent.

The buffer side works like a first-word-fall-through queue. The current word is always present on `word_in`, and the block pulses `word_take` in the cycle that uses the last needed nibble of that word, so the buffer can step forward on that edge. A phase controller selects the source of each nibble: preamble, data, pad or FCS. A CRC unit follows the selected nibbles, and a registered output multiplexer drives the MII pins.

Top module: `mii_frame_tx`

## Requirements
- R1: While reset is held and after its release, `mii_txen`, `mii_txd`, `word_take` and `busy` are all zero until a start request is accepted.
- R2: A start request sampled while idle makes `busy` high after that edge. `mii_txen` rises one edge later. The first 16 nibbles on `mii_txd` are fifteen 0x5 nibbles followed by 0xD: seven 0x55 bytes and the delimiter byte 0xD5, each sent low nibble first.
- R3: Payload byte k comes from bits [8*(k mod 4)+7 : 8*(k mod 4)] of the (k/4)-th word, with the low nibble sent before the high nibble. `word_take` pulses exactly once per word used, which is ceil(len/4) times per frame.
- R4: When `len` is below MIN_BYTES (60), zero nibbles follow the payload until payload plus pad reaches 60 bytes. When `len` is 60 or more, no pad is sent.
- R5: The last 8 nibbles carry the complement of a CRC-32 (polynomial 0x04C11DB7 in reflected form, register preset to all ones) taken over the payload and pad, least significant nibble first. Running the same CRC over body plus FCS leaves the residue 0xDEBB20E3.
- R6: `mii_txen` stays high without a gap for exactly 16 + 2*max(len,60) + 8 nibbles. `mii_txd` is zero whenever `mii_txen` is low.
- R7: A start request that arrives while `busy` is high is ignored. The frame in progress keeps its length and content, and no second frame follows.
- R8: A length of 0 gives a frame of 60 zero pad bytes plus FCS, and no word is taken.
- R9: `busy` falls in the cycle that presents the last FCS nibble on the pins. `mii_txen` falls one cycle later, and a new start is accepted from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one nibble per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send a frame, taken only while idle |
| len | input | LEN_W | Payload byte count, 0 to MAX_BYTES, captured with start |
| word_in | input | 32 | Current buffer word, byte 0 in bits 7:0 |
| word_take | output | 1 | Current word fully used; buffer advances at this edge |
| busy | output | 1 | Frame in progress inside the controller |
| mii_txen | output | 1 | MII transmit enable |
| mii_txd | output | 4 | MII transmit data nibble |

## Verification
The bench builds the block with MAX_BYTES = 100 and the standard MIN_BYTES = 60. This keeps the length port at 7 bits and lets the largest frame finish in a little over 200 cycles. With these values, the full-length frame, the pad boundary at 59, 60 and 61 bytes, the empty payload, and a partial last word can all be reached in one short run, together with random lengths across the whole range. The FCS of every frame is checked both against a byte-wise CRC model and by its residue.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_DATA,
    PH_PAD,
    PH_FCS
  } phase_t;

  localparam logic [3:0]  NIB_PREAMBLE = 4'h5;
  localparam logic [3:0]  NIB_DELIM_HI = 4'hD;
  localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET   = 32'hFFFFFFFF;

  // Advance a reflected CRC-32 register by one nibble, bit 0 first.
  function automatic logic [31:0] crc_step_nib(input logic [31:0] c, input logic [3:0] n);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 4; i++) begin
      fb = r[0] ^ n[i];
      r  = r >> 1;
      if (fb) r = r ^ CRC_POLY_REV;
    end
    return r;
  endfunction

  // Pick nibble idx of the complemented register, lowest nibble at idx 0.
  function automatic logic [3:0] fcs_nib(input logic [31:0] c, input logic [2:0] idx);
    logic [31:0] inv;
    inv = ~c;
    return inv[{idx, 2'b00} +: 4];
  endfunction

endpackage

// File: rtl/mii_tx_ctrl.sv
module mii_tx_ctrl
  import mii_tx_pkg::*;
#(
  parameter int MAX_BYTES = 1500,
  parameter int MIN_BYTES = 60,
  parameter int LEN_W     = 11,
  parameter int NIB_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output phase_t           phase,
  output logic [3:0]       ph_cnt,
  output logic [NIB_W-1:0] body_cnt,
  output logic             word_take,
  output logic             busy
);

  localparam logic [NIB_W-1:0] PAD_END = NIB_W'(2 * MIN_BYTES - 1);

  logic [LEN_W-1:0] len_q;
  logic [NIB_W-1:0] data_end;
  logic             data_last;

  assign data_end  = NIB_W'({len_q, 1'b0}) - NIB_W'(1);
  assign data_last = (phase == PH_DATA) && (body_cnt == data_end);
  assign word_take = (phase == PH_DATA) && ((body_cnt[2:0] == 3'd7) || data_last);
  assign busy      = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      ph_cnt   <= '0;
      body_cnt <= '0;
      len_q    <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            len_q  <= len;
            phase  <= PH_PRE;
            ph_cnt <= '0;
          end
        end
        PH_PRE: begin
          ph_cnt   <= ph_cnt + 4'd1;
          body_cnt <= '0;
          if (ph_cnt == 4'd15) phase <= (len_q == '0) ? PH_PAD : PH_DATA;
        end
        PH_DATA: begin
          body_cnt <= body_cnt + NIB_W'(1);
          if (data_last) begin
            phase  <= (body_cnt < PAD_END) ? PH_PAD : PH_FCS;
            ph_cnt <= '0;
          end
        end
        PH_PAD: begin
          body_cnt <= body_cnt + NIB_W'(1);
          if (body_cnt == PAD_END) begin
            phase  <= PH_FCS;
            ph_cnt <= '0;
          end
        end
        PH_FCS: begin
          ph_cnt <= ph_cnt + 4'd1;
          if (ph_cnt == 4'd7) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mii_tx_crc.sv
module mii_tx_crc
  import mii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  phase_t      phase,
  input  logic [3:0]  nib,
  output logic [31:0] crc
);

  always_ff @(posedge clk) begin
    if (!rst_n)                                    crc <= CRC_PRESET;
    else if (phase == PH_PRE)                      crc <= CRC_PRESET;
    else if (phase == PH_DATA || phase == PH_PAD)  crc <= crc_step_nib(crc, nib);
  end

endmodule

// File: rtl/mii_tx_mux.sv
module mii_tx_mux
  import mii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  phase_t      phase,
  input  logic [3:0]  ph_cnt,
  input  logic [2:0]  nib_idx,
  input  logic [31:0] word_in,
  input  logic [31:0] crc,
  output logic [3:0]  nib,
  output logic        txen,
  output logic [3:0]  txd
);

  always_comb begin
    case (phase)
      PH_PRE:  nib = (ph_cnt == 4'd15) ? NIB_DELIM_HI : NIB_PREAMBLE;
      PH_DATA: nib = word_in[{nib_idx, 2'b00} +: 4];
      PH_FCS:  nib = fcs_nib(crc, ph_cnt[2:0]);
      default: nib = 4'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txen <= 1'b0;
      txd  <= 4'h0;
    end else begin
      txen <= (phase != PH_IDLE);
      txd  <= nib;
    end
  end

endmodule

// File: rtl/mii_frame_tx.sv
module mii_frame_tx
  import mii_tx_pkg::*;
#(
  parameter int  MAX_BYTES = 1500,
  parameter int  MIN_BYTES = 60,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int NIB_W     = $clog2(2 * MAX_BYTES + 2 * MIN_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [31:0]      word_in,
  output logic             word_take,
  output logic             busy,
  output logic             mii_txen,
  output logic [3:0]       mii_txd
);

  phase_t           phase;
  logic [3:0]       ph_cnt;
  logic [NIB_W-1:0] body_cnt;
  logic [3:0]       nib_sel;
  logic [31:0]      crc_reg;
  logic             sel_pad;

  assign sel_pad = (phase == PH_PAD);

  mii_tx_ctrl #(
    .MAX_BYTES(MAX_BYTES), .MIN_BYTES(MIN_BYTES), .LEN_W(LEN_W), .NIB_W(NIB_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len),
    .phase(phase), .ph_cnt(ph_cnt), .body_cnt(body_cnt),
    .word_take(word_take), .busy(busy)
  );

  mii_tx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .phase(phase), .nib(nib_sel), .crc(crc_reg)
  );

  mii_tx_mux u_mux (
    .clk(clk), .rst_n(rst_n), .phase(phase), .ph_cnt(ph_cnt),
    .nib_idx(body_cnt[2:0]), .word_in(word_in), .crc(crc_reg),
    .nib(nib_sel), .txen(mii_txen), .txd(mii_txd)
  );

endmodule

// File: rtl/mii_tx_chk.sv
module mii_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       word_take,
  input logic       txen,
  input logic [3:0] txd,
  input logic       in_pad
);

  // R6: idle pins carry zero data
  a_r6_txd_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !txen |-> (txd == 4'h0));

  // R2: enable follows busy by one edge
  a_r2_txen_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> txen);

  // R2: first nibble on the pins is preamble
  a_r2_first_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txen) |-> (txd == 4'h5));

  // R4: a selected pad nibble reaches the pins as zero
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_pad |=> (txd == 4'h0));

  // R3: words are only taken inside a frame
  a_r3_take_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |-> busy);

  // R9: enable drops only after the controller went idle
  a_r9_end_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txen) |-> !busy);

  // R1: reset clears the pins
  always @(posedge clk)
    if (!rst_n) a_r1_reset_quiet: assert (!txen && txd == 4'h0);

endmodule

bind mii_frame_tx mii_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .word_take(word_take),
  .txen(mii_txen), .txd(mii_txd), .in_pad(sel_pad)
);

// File: tb/sim_mii_frame_tx.sv
module sim_mii_frame_tx;

  localparam int MAXB  = 100;
  localparam int MINB  = 60;
  localparam int LEN_W = $clog2(MAXB + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic [31:0]      word_in;
  logic             word_take, busy, mii_txen;
  logic [3:0]       mii_txd;

  logic [31:0] mem [0:1023];
  logic [9:0]  ptr;
  logic        take_s = 1'b0;
  int          take_cnt = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  logic [3:0] cap  [0:511];
  logic [7:0] pay  [0:255];

  always #10 clk = ~clk;

  mii_frame_tx #(.MAX_BYTES(MAXB), .MIN_BYTES(MINB)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len), .word_in(word_in),
    .word_take(word_take), .busy(busy), .mii_txen(mii_txen), .mii_txd(mii_txd)
  );

  assign word_in = mem[ptr];

  always @(negedge clk) begin
    take_s <= word_take;
    if (rst_n && word_take) take_cnt <= take_cnt + 1;
  end

  always @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (take_s) ptr <= ptr + 10'd1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Byte-wise reflected CRC-32 model
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic run_frame(input int n, input bit poke);
    int          idx, nb, total, wp, t0, bad;
    logic [31:0] c, got;
    logic [7:0]  b;
    wp = int'(ptr);
    for (int i = 0; i < n; i++) begin
      pay[i] = 8'($urandom);
      mem[(wp + i / 4) % 1024][8 * (i % 4) +: 8] = pay[i];
    end
    t0 = take_cnt;
    @(negedge clk); start = 1'b1; len = LEN_W'(n);
    @(negedge clk); start = 1'b0;
    chk(busy && !mii_txen, "R2", "busy/txen after start", {busy, mii_txen}, 2'b10);
    @(negedge clk);
    chk(mii_txen, "R2", "txen one edge later", mii_txen, 1);
    idx = 0;
    while (mii_txen && idx < 500) begin
      cap[idx] = mii_txd;
      idx++;
      if (poke && idx == 20) begin start = 1'b1; len = LEN_W'(7); end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(!busy, "R9", "busy low when txen falls", busy, 0);
    chk(mii_txd == 4'h0, "R6", "txd zero when idle", mii_txd, 0);
    nb = 2 * ((n > MINB) ? n : MINB);
    total = 16 + nb + 8;
    chk(idx == total, "R6", "nibbles with txen high", idx, total);
    bad = 0;
    for (int i = 0; i < 16; i++) if (cap[i] != ((i == 15) ? 4'hD : 4'h5)) bad++;
    chk(bad == 0, "R2", "preamble/delimiter errors", bad, 0);
    bad = 0; c = 32'hFFFFFFFF;
    for (int k = 0; k < nb / 2; k++) begin
      b = (k < n) ? pay[k] : 8'h00;
      if (cap[16 + 2 * k] != b[3:0] || cap[17 + 2 * k] != b[7:4]) bad++;
      c = crc_byte(c, b);
    end
    if (n == 0)      chk(bad == 0, "R8", "empty payload pad errors", bad, 0);
    else if (n < MINB) chk(bad == 0, "R4", "payload+pad errors", bad, 0);
    else             chk(bad == 0, "R3", "payload nibble errors", bad, 0);
    got = '0;
    for (int i = 0; i < 8; i++) got[4 * i +: 4] = cap[16 + nb + i];
    chk(got == ~c, "R5", "FCS value", got, ~c);
    c = 32'hFFFFFFFF;
    for (int k = 0; k < nb / 2 + 4; k++) c = crc_byte(c, {cap[17 + 2 * k], cap[16 + 2 * k]});
    chk(c == 32'hDEBB20E3, "R5", "CRC residue", c, 32'hDEBB20E3);
    chk(take_cnt - t0 == (n + 3) / 4, "R3", "word_take pulses", take_cnt - t0, (n + 3) / 4);
    @(negedge clk);
    if (poke) chk(!busy && !mii_txen, "R7", "no frame from ignored start", {busy, mii_txen}, 0);
    else      chk(!busy && !mii_txen, "R9", "idle after frame", {busy, mii_txen}, 0);
  endtask

  initial begin
    int dir [0:7];
    dir = '{0, 1, 3, 4, 59, 60, 61, 100};
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!mii_txen && mii_txd == 0 && !busy && !word_take, "R1", "outputs in reset",
        {mii_txen, mii_txd, busy, word_take}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mii_txen && mii_txd == 0 && !busy && !word_take, "R1", "outputs after reset",
        {mii_txen, mii_txd, busy, word_take}, 0);
    for (int i = 0; i < 8; i++) run_frame(dir[i], dir[i] == 61);
    for (int i = 0; i < 8; i++) run_frame(int'($urandom_range(0, MAXB)), 1'b0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule